// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block sits on the address path of a synchronous burst memory. On a clock edge where either of two independent start strobes is active, it captures the full external address and presents it as the first array address of a four-beat burst. On later edges where the advance input is active, it steps a two-bit beat count. It then presents the next address of the group, changing only the two lowest address bits.

The order of the low bits is chosen by a mode input. In exclusive-or order, the low bits equal the captured low bits XOR the beat count. In linear order, they equal the captured low bits plus the beat count, modulo 4. The mode is sampled on every edge. All inputs are sampled on the rising clock edge, and the output address is a register.

Top module: `burst_addr_gen`

## Requirements
- R1: On the cycle after an edge with `rst` high, `addr_out` is 0. The stored start address and the beat count are cleared, so a single advance after reset gives `addr_out` = 1 in either order.
- R2: An edge on which `cpu_start_n` or `ctl_start_n` is low (active-low, either one alone suffices) loads `addr_in`. `addr_out` after that edge equals that `addr_in`, and the beat count restarts at 0.
- R3: When a start strobe and `adv_n` are both low on the same edge, the start wins. `addr_out` after that edge equals `addr_in` and no step is taken.
- R4: An edge with `adv_n` low and both strobes high adds 1 to the beat count, modulo 4, so the low bits of `addr_out` change on every such edge.
- R5: An edge with `adv_n` high, both strobes high and `order_lin` unchanged leaves `addr_out` unchanged.
- R6: With `order_lin` = 0 (exclusive-or order), `addr_out[1:0]` = start[1:0] XOR beat.
- R7: With `order_lin` = 1 (linear order), `addr_out[1:0]` = (start[1:0] + beat) mod 4.
- R8: Between starts, `addr_out[16:2]` never changes. After the fourth beat, further advances wrap within the same four-address group.
- R9: The order is taken from `order_lin` as sampled on each edge. Changing it in mid-burst re-maps the current beat in the new order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| addr_in | input | 17 | External start address |
| cpu_start_n | input | 1 | Processor-side burst start strobe, active low |
| ctl_start_n | input | 1 | Controller-side burst start strobe, active low |
| adv_n | input | 1 | Advance to next beat, active low |
| order_lin | input | 1 | 0 = exclusive-or order, 1 = linear order |
| addr_out | output | 17 | Registered array address |

## Verification
Every start offset from 0 to 3 is run in both orders for six advances. This separates the two orders, because they differ only for offsets 1 and 3, and it exposes any carry out of the low bits at the wrap. Start addresses with all upper bits set show a carry into bit 2. Directed edges combine a strobe with an advance, and a mode flip in mid-burst, to separate the start priority and per-edge mode sampling from a design that latches the mode at the start. Long random runs mix the strobes, advance gaps and mode changes to cover holds between beats.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic {
    ORD_XOR = 1'b0,
    ORD_LIN = 1'b1
  } order_e;
endpackage

// File: rtl/burst_start_reg.sv
module burst_start_reg #(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] start_d
);
  logic [ADDR_W-1:0] start_q;

  assign start_d = load ? addr_in : start_q;

  always_ff @(posedge clk) begin
    if (rst) start_q <= '0;
    else     start_q <= start_d;
  end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              step,
  output logic [BEAT_W-1:0] beat_d
);
  logic [BEAT_W-1:0] beat_q;

  always_comb begin
    if (clr)       beat_d = '0;
    else if (step) beat_d = beat_q + 1'b1;
    else           beat_d = beat_q;
  end

  always_ff @(posedge clk) begin
    if (rst) beat_q <= '0;
    else     beat_q <= beat_d;
  end
endmodule

// File: rtl/burst_low_map.sv
module burst_low_map
  import burst_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start_lo,
  input  logic [BEAT_W-1:0] beat,
  input  order_e            order,
  output logic [BEAT_W-1:0] low
);
  logic [BEAT_W-1:0] low_xor;
  logic [BEAT_W-1:0] low_lin;

  for (genvar i = 0; i < BEAT_W; i++) begin : g_xor
    assign low_xor[i] = start_lo[i] ^ beat[i];
  end

  assign low_lin = start_lo + beat;

  always_comb begin
    case (order)
      ORD_LIN: low = low_lin;
      default: low = low_xor;
    endcase
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              cpu_start_n,
  input  logic              ctl_start_n,
  input  logic              adv_n,
  input  logic              order_lin,
  output logic [ADDR_W-1:0] addr_out
);
  localparam int HI_W = ADDR_W - BEAT_W;

  logic              load;
  logic              step;
  logic [ADDR_W-1:0] start_d;
  logic [BEAT_W-1:0] beat_d;
  logic [BEAT_W-1:0] low_d;
  order_e            order;

  assign load  = ~cpu_start_n | ~ctl_start_n;
  assign step  = ~adv_n & ~load;
  assign order = order_e'(order_lin);

  burst_start_reg #(.ADDR_W(ADDR_W)) u_start (
    .clk(clk), .rst(rst), .load(load), .addr_in(addr_in), .start_d(start_d)
  );

  burst_beat_ctr #(.BEAT_W(BEAT_W)) u_beat (
    .clk(clk), .rst(rst), .clr(load), .step(step), .beat_d(beat_d)
  );

  burst_low_map #(.BEAT_W(BEAT_W)) u_map (
    .start_lo(start_d[BEAT_W-1:0]), .beat(beat_d), .order(order), .low(low_d)
  );

  always_ff @(posedge clk) begin
    if (rst) addr_out <= '0;
    else     addr_out <= {start_d[ADDR_W-1 -: HI_W], low_d};
  end
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W = 17,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr_in,
  input logic              cpu_start_n,
  input logic              ctl_start_n,
  input logic              adv_n,
  input logic              order_lin,
  input logic [ADDR_W-1:0] addr_out
);
  // R1
  reset_zero_chk: assert property (@(posedge clk) rst |=> addr_out == '0);

  // R2 R3
  start_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!cpu_start_n || !ctl_start_n) |=> addr_out == $past(addr_in));

  // R4
  adv_moves_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_start_n && ctl_start_n && !adv_n && order_lin == $past(order_lin))
    |=> addr_out[BEAT_W-1:0] != $past(addr_out[BEAT_W-1:0]));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_start_n && ctl_start_n && adv_n && order_lin == $past(order_lin))
    |=> $stable(addr_out));

  // R8
  upper_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_start_n && ctl_start_n)
    |=> addr_out[ADDR_W-1:BEAT_W] == $past(addr_out[ADDR_W-1:BEAT_W]));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
  .clk(clk), .rst(rst), .addr_in(addr_in), .cpu_start_n(cpu_start_n),
  .ctl_start_n(ctl_start_n), .adv_n(adv_n), .order_lin(order_lin),
  .addr_out(addr_out)
);

// File: tb/tb_burst_addr_gen.sv
`timescale 1ns/1ps
module tb_burst_addr_gen;
  localparam int AW = 17;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic          cpu_start_n = 1'b1;
  logic          ctl_start_n = 1'b1;
  logic          adv_n = 1'b1;
  logic          order_lin = 1'b0;
  logic [AW-1:0] addr_out;

  int checks = 0;
  int fails  = 0;
  logic [AW-1:0] m_start = '0;
  logic [1:0]    m_beat  = '0;
  logic          m_lin   = 1'b0;

  always #10 clk = ~clk;

  burst_addr_gen dut (
    .clk(clk), .rst(rst), .addr_in(addr_in), .cpu_start_n(cpu_start_n),
    .ctl_start_n(ctl_start_n), .adv_n(adv_n), .order_lin(order_lin),
    .addr_out(addr_out)
  );

  function automatic logic [1:0] ref_low(logic [1:0] s, logic [1:0] b, logic lin);
    return lin ? 2'(s + b) : (s ^ b);
  endfunction

  function automatic logic [AW-1:0] ref_addr();
    return {m_start[AW-1:2], ref_low(m_start[1:0], m_beat, m_lin)};
  endfunction

  task automatic check(logic [AW-1:0] exp, string req);
    checks++;
    if (addr_out !== exp) begin
      fails++;
      $display("FAIL %s: addr_out=%h expected %h", req, addr_out, exp);
    end
  endtask

  // Called at a falling edge: drive, pass one rising edge, compare at the next falling edge.
  task automatic cyc(logic r, logic [AW-1:0] a, logic cs, logic ks, logic av, logic lin, string req);
    rst = r; addr_in = a; cpu_start_n = cs; ctl_start_n = ks; adv_n = av; order_lin = lin;
    @(posedge clk);
    m_lin = lin;
    if (r) begin m_start = '0; m_beat = '0; end
    else if (!cs || !ks) begin m_start = a; m_beat = '0; end
    else if (!av) m_beat = m_beat + 2'd1;
    @(negedge clk);
    check(r ? '0 : ref_addr(), req);
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog: timeout expired=1 expected 0");
    $display("%0d/%0d checks passed", checks - fails, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    cyc(1, 17'h1ABCD, 0, 1, 0, 1, "R1");
    cyc(1, '0, 1, 1, 1, 0, "R1");
    check('0, "R1");
    cyc(0, 17'h15555, 1, 1, 0, 0, "R1");
    check(17'h00001, "R1");

    // Every offset in both orders, six advances to cover the wrap.
    for (int lin = 0; lin < 2; lin++) begin
      for (int off = 0; off < 4; off++) begin
        logic [AW-1:0] base;
        base = {15'h7FFF, 2'(off)};
        cyc(0, base, (off % 2 == 0) ? 1'b0 : 1'b1, (off % 2 == 0) ? 1'b1 : 1'b0,
            1, 1'(lin), "R2");
        for (int k = 0; k < 6; k++)
          cyc(0, 17'h0, 1, 1, 0, 1'(lin), lin ? "R7" : "R6");
        check({15'h7FFF, ref_low(2'(off), 2'd2, 1'(lin))}, "R8");
      end
    end

    // Priority: start and advance on the same edge.
    cyc(0, 17'h00101, 1, 1, 0, 0, "R4");
    cyc(0, 17'h0A0A2, 0, 0, 0, 0, "R3");
    check(17'h0A0A2, "R3");
    // Hold with no advance.
    cyc(0, 17'h1FFFF, 1, 1, 1, 0, "R5");
    cyc(0, 17'h1FFFF, 1, 1, 1, 0, "R5");
    check(17'h0A0A2, "R5");
    // Mid-burst mode flip: start 1, beat 1 -> xor 0, linear 2.
    cyc(0, 17'h00201, 1, 0, 1, 0, "R2");
    cyc(0, 17'h0, 1, 1, 0, 0, "R6");
    check(17'h00200, "R6");
    cyc(0, 17'h0, 1, 1, 1, 1, "R9");
    check(17'h00202, "R9");

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom();
      cyc((r[7:0] == 8'h00), 17'($urandom()), (r[11:9] != 3'd0), (r[14:12] != 3'd0),
          r[15] & r[16], (r[20:18] == 3'd0) ? ~m_lin : m_lin, "R4");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule